// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits beside the execute stage of a five-stage in-order integer pipeline. For each of the two ALU operands of the instruction now executing, it decides whether the operand should come from the register file, or from a result that a later stage already holds but has not yet written back. A result from the instruction one ahead is held in the execute/memory pipeline register. A result from the instruction two ahead is held in the memory/writeback pipeline register. Because the selector picks these in-flight results, a run of dependent instructions can proceed back to back with no stall.

The selection is purely combinational. There is no clock, no state and no handshake, because every input is a field that the pipeline registers already hold. The block drives a 2-bit select for each operand and also drives the two chosen 32-bit operand values through its own muxes. A stage offers its result only when it will write a register and its destination is not register zero. When both stages hold the same destination, the younger result from the execute/memory register is used.

Load-use stalls, branch-operand bypass and store-data bypass are handled elsewhere. A load followed at once by a consumer of its result still needs a one-cycle stall from a separate hazard unit.

Top module: `fwd_unit_top`

## Requirements
- R1: Select encoding is 2'b00 for the register-file value, 2'b10 for the execute/memory result and 2'b01 for the memory/writeback value. When no stage qualifies, the select is 2'b00 and the operand equals the register-file input.
- R2: When the execute/memory stage has its write flag set, a nonzero destination, and a destination equal to an operand's source number, that operand's select is 2'b10 and the operand equals the execute/memory result.
- R3: When only the memory/writeback stage qualifies (write flag set, nonzero destination equal to the source number), the select is 2'b01 and the operand equals the memory/writeback value.
- R4: When both stages qualify for the same operand, the execute/memory result wins (select 2'b10).
- R5: A stage whose destination is register 0 is never bypassed, even when the source number is 0 and the write flag is set.
- R6: A stage whose write flag is clear is never bypassed, whatever its destination.
- R7: The two operands are selected independently. In one cycle they may take different sources, or both may take the same stage.
- R8: A select output never takes the value 2'b11.
- R9: In a chain where one instruction writes register r and the next three instructions read r, each consumer receives the produced value with no stall. The first consumer gets it by execute/memory bypass, the second by memory/writeback bypass, and the third from the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register number of the executing instruction |
| ex_src_b | input | 5 | Second source register number of the executing instruction |
| rf_val_a | input | 32 | Register-file read value for the first operand |
| rf_val_b | input | 32 | Register-file read value for the second operand |
| em_dst | input | 5 | Destination register held in the execute/memory register |
| em_wen | input | 1 | Register-write flag held in the execute/memory register |
| em_result | input | 32 | ALU result held in the execute/memory register |
| mw_dst | input | 5 | Destination register held in the memory/writeback register |
| mw_wen | input | 1 | Register-write flag held in the memory/writeback register |
| mw_value | input | 32 | Writeback value held in the memory/writeback register |
| sel_a | output | 2 | Source select for the first operand |
| sel_b | output | 2 | Source select for the second operand |
| opnd_a | output | 32 | Chosen first ALU operand |
| opnd_b | output | 32 | Chosen second ALU operand |

## Verification
The two functions that can coincide are the execute/memory match and the memory/writeback match on the same source number. The bench provokes this by giving both stages one destination, and it also biases random register numbers toward a small range so that such double hits, and hits on register zero, occur often. The check is judged against a bench function that applies the priority, zero guard and write-flag guard. Both operands are compared in every cycle, so a case where the two operands hit different stages at once is judged in the same pass.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int REG_ADDR_W = 5;
  localparam int DATA_W     = 32;
  localparam int SEL_W      = 2;
  localparam int NUM_OPND   = 2;

  typedef logic [SEL_W-1:0] fwd_sel_t;

  localparam fwd_sel_t SEL_REGFILE = 2'b00;
  localparam fwd_sel_t SEL_MEMWB   = 2'b01;
  localparam fwd_sel_t SEL_EXMEM   = 2'b10;
endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic              wen,
  output logic              hit
);
  logic dst_nonzero;

  always_comb begin
    dst_nonzero = |dst;
    hit = wen && dst_nonzero && (dst == src);
  end

  // R5 / R6: a hit requires a writing stage with a nonzero destination
  always_comb begin
    if (hit) begin
      p_hit_guard_r5: assert (wen && (dst != '0))
        else $error("hit without write flag or with register 0");
    end
  end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
(
  input  logic     hit_em,
  input  logic     hit_mw,
  output fwd_sel_t sel
);
  always_comb begin
    if (hit_em)      sel = SEL_EXMEM;
    else if (hit_mw) sel = SEL_MEMWB;
    else             sel = SEL_REGFILE;
  end

  always_comb begin
    p_newer_wins_r4: assert (!(hit_em && hit_mw) || sel == SEL_EXMEM)
      else $error("older stage chosen over newer");
    p_sel_legal_r8: assert (sel != 2'b11)
      else $error("illegal select");
  end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
  import fwd_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  fwd_sel_t         sel,
  input  logic [WIDTH-1:0] rf_val,
  input  logic [WIDTH-1:0] em_val,
  input  logic [WIDTH-1:0] mw_val,
  output logic [WIDTH-1:0] opnd
);
  always_comb begin
    unique case (sel)
      SEL_EXMEM: opnd = em_val;
      SEL_MEMWB: opnd = mw_val;
      default:   opnd = rf_val;
    endcase
  end
endmodule

// File: rtl/fwd_unit_top.sv
module fwd_unit_top
  import fwd_pkg::*;
#(
  parameter int ADDR_W = REG_ADDR_W,
  parameter int WIDTH  = DATA_W
) (
  input  logic [ADDR_W-1:0] ex_src_a,
  input  logic [ADDR_W-1:0] ex_src_b,
  input  logic [WIDTH-1:0]  rf_val_a,
  input  logic [WIDTH-1:0]  rf_val_b,
  input  logic [ADDR_W-1:0] em_dst,
  input  logic              em_wen,
  input  logic [WIDTH-1:0]  em_result,
  input  logic [ADDR_W-1:0] mw_dst,
  input  logic              mw_wen,
  input  logic [WIDTH-1:0]  mw_value,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [WIDTH-1:0]  opnd_a,
  output logic [WIDTH-1:0]  opnd_b
);
  localparam int N = NUM_OPND;

  logic [ADDR_W-1:0] src_v [N];
  logic [WIDTH-1:0]  rf_v  [N];
  fwd_sel_t          sel_v [N];
  logic [WIDTH-1:0]  op_v  [N];

  assign src_v[0] = ex_src_a;
  assign src_v[1] = ex_src_b;
  assign rf_v[0]  = rf_val_a;
  assign rf_v[1]  = rf_val_b;

  for (genvar i = 0; i < N; i++) begin : g_opnd
    logic hit_em;
    logic hit_mw;

    fwd_hit #(.ADDR_W(ADDR_W)) u_hit_em (
      .src(src_v[i]), .dst(em_dst), .wen(em_wen), .hit(hit_em)
    );
    fwd_hit #(.ADDR_W(ADDR_W)) u_hit_mw (
      .src(src_v[i]), .dst(mw_dst), .wen(mw_wen), .hit(hit_mw)
    );
    fwd_pick u_pick (
      .hit_em(hit_em), .hit_mw(hit_mw), .sel(sel_v[i])
    );
    fwd_opmux #(.WIDTH(WIDTH)) u_mux (
      .sel(sel_v[i]), .rf_val(rf_v[i]), .em_val(em_result),
      .mw_val(mw_value), .opnd(op_v[i])
    );
  end

  assign sel_a  = sel_v[0];
  assign sel_b  = sel_v[1];
  assign opnd_a = op_v[0];
  assign opnd_b = op_v[1];

  // Port-level relations between the selects and the chosen operands
  always_comb begin
    if (sel_a == SEL_EXMEM) begin
      p_opa_em_r2: assert (opnd_a == em_result) else $error("opnd_a not em_result");
    end
    if (sel_a == SEL_MEMWB) begin
      p_opa_mw_r3: assert (opnd_a == mw_value) else $error("opnd_a not mw_value");
    end
    if (sel_b == SEL_REGFILE) begin
      p_opb_rf_r1: assert (opnd_b == rf_val_b) else $error("opnd_b not rf_val_b");
    end
    if (!em_wen && !mw_wen) begin
      p_no_wen_r6: assert (sel_a == SEL_REGFILE && sel_b == SEL_REGFILE)
        else $error("bypass without any write flag");
    end
    if (em_dst == '0 && mw_dst == '0) begin
      p_zero_dst_r5: assert (sel_a == SEL_REGFILE && sel_b == SEL_REGFILE)
        else $error("bypass of register 0");
    end
  end
endmodule

// File: tb/fwd_unit_top_tb_top.sv
module fwd_unit_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0]  ex_src_a, ex_src_b, em_dst, mw_dst;
  logic [31:0] rf_val_a, rf_val_b, em_result, mw_value;
  logic        em_wen, mw_wen;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  fwd_unit_top dut_i (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
    .em_dst(em_dst), .em_wen(em_wen), .em_result(em_result),
    .mw_dst(mw_dst), .mw_wen(mw_wen), .mw_value(mw_value),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  function automatic logic [1:0] exp_sel(input logic [4:0] src);
    if (em_wen && em_dst != 5'd0 && em_dst == src) return 2'b10;
    if (mw_wen && mw_dst != 5'd0 && mw_dst == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] exp_val(input logic [1:0] s, input logic [31:0] rf);
    if (s == 2'b10) return em_result;
    if (s == 2'b01) return mw_value;
    return rf;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] sa, input logic [4:0] sb,
                       input logic [4:0] ed, input logic ew,
                       input logic [4:0] md, input logic mw);
    @(negedge clk);
    ex_src_a = sa; ex_src_b = sb;
    em_dst = ed; em_wen = ew; mw_dst = md; mw_wen = mw;
    rf_val_a  = $urandom; rf_val_b = $urandom;
    em_result = $urandom; mw_value = $urandom;
    #1;
  endtask

  task automatic check_both(input string req);
    logic [1:0] ea, eb;
    ea = exp_sel(ex_src_a);
    eb = exp_sel(ex_src_b);
    check(req, {30'd0, sel_a}, {30'd0, ea});
    check(req, {30'd0, sel_b}, {30'd0, eb});
    check(req, opnd_a, exp_val(ea, rf_val_a));
    check(req, opnd_b, exp_val(eb, rf_val_b));
    check("R8", {31'd0, (sel_a == 2'b11) || (sel_b == 2'b11)}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    ex_src_a = '0; ex_src_b = '0; em_dst = '0; mw_dst = '0;
    em_wen = 0; mw_wen = 0;
    rf_val_a = 32'h1111_1111; rf_val_b = 32'h2222_2222;
    em_result = 32'h3333_3333; mw_value = 32'h4444_4444;
    #1;
    // R1: idle inputs select the register file
    check("R1", {30'd0, sel_a}, 32'd0);
    check("R1", opnd_b, 32'h2222_2222);

    apply(5'd3, 5'd4, 5'd7, 1, 5'd8, 1);   check_both("R1");
    apply(5'd3, 5'd4, 5'd3, 1, 5'd9, 1);   check_both("R2");
    check("R2", {30'd0, sel_a}, 32'd2);
    apply(5'd6, 5'd5, 5'd1, 1, 5'd5, 1);   check_both("R3");
    check("R3", {30'd0, sel_b}, 32'd1);
    apply(5'd9, 5'd9, 5'd9, 1, 5'd9, 1);   check_both("R4");
    check("R4", {30'd0, sel_a}, 32'd2);
    check("R4", opnd_b, em_result);
    apply(5'd0, 5'd0, 5'd0, 1, 5'd0, 1);   check_both("R5");
    check("R5", opnd_a, rf_val_a);
    apply(5'd12, 5'd13, 5'd12, 0, 5'd13, 0); check_both("R6");
    check("R6", opnd_b, rf_val_b);
    apply(5'd12, 5'd13, 5'd12, 0, 5'd12, 1); check_both("R6");
    check("R6", {30'd0, sel_a}, 32'd1);
    apply(5'd10, 5'd11, 5'd10, 1, 5'd11, 1); check_both("R7");
    check("R7", {28'd0, sel_a, sel_b}, 32'h9);

    // R9: producer writes r1 with value V; three consumers read r1
    begin
      logic [31:0] v;
      v = 32'hCAFE_0001;
      @(negedge clk);
      ex_src_a = 5'd1; ex_src_b = 5'd5; rf_val_a = 32'h0; rf_val_b = 32'h55;
      em_dst = 5'd1; em_wen = 1; em_result = v; mw_dst = 5'd0; mw_wen = 0;
      #1; check("R9", opnd_a, v);
      @(negedge clk);
      ex_src_a = 5'd1; ex_src_b = 5'd7; rf_val_a = 32'h0;
      em_dst = 5'd4; em_wen = 1; em_result = 32'h0BAD_0004;
      mw_dst = 5'd1; mw_wen = 1; mw_value = v;
      #1; check("R9", opnd_a, v);
      @(negedge clk);
      ex_src_a = 5'd5; ex_src_b = 5'd1; rf_val_b = v;
      em_dst = 5'd6; em_result = 32'h0BAD_0006; mw_dst = 5'd4; mw_value = 32'h0BAD_0004;
      #1; check("R9", opnd_b, v);
    end

    // Random mix, registers biased to 0..3 to provoke double hits
    for (int k = 0; k < 3000; k++) begin
      logic [4:0] m;
      m = (k % 3 == 0) ? 5'h1F : 5'h03;
      apply(5'($urandom) & m, 5'($urandom) & m, 5'($urandom) & m, 1'($urandom),
            5'($urandom) & m, 1'($urandom));
      check_both("R4");
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule